// File: doc/BRIEF.md
# Four-Lane Sum-of-Products Unit for a 16-bit Float Format

This block forms the dot product of two four-element vectors whose elements use a compact 16-bit floating-point layout: a sign bit at bit 15, a six-bit biased exponent in bits 14:9 (bias 31) and a nine-bit fraction in bits 8:0 with an implicit leading one. Each lane multiplies its pair of operands exactly. The four products are added exactly, with no intermediate rounding. The total is then normalized and rounded once, to nearest with ties to even, back into the same 16-bit layout.

The arithmetic path is purely combinational. A parameter adds an output register with a synchronous, active-high reset. When the register is present the result appears one clock after the operands. When it is absent the result is valid in the same cycle. The result is one 16-bit word, so a narrow top level can split it into a high byte and a low byte. Only normal numbers, zero and sign are handled. Subnormal inputs are read as zero, and the top exponent code is an ordinary finite exponent.

Top module: `fp16c_dot4`

## Requirements
- R1: Element encoding is sign at bit 15, exponent field at bits 14:9 and fraction at bits 8:0, with value (1.fraction) x 2^(exponent-31). 1.0 is 0x3E00, 2.0 is 0x4000, 3.0 is 0x4100 and 4.0 is 0x4200, so 3.0 times 2.0 gives 0x4300.
- R2: With both vectors equal to {1.0, 2.0, 3.0, 4.0}, the result is 30.0, encoded as 0x47C0.
- R3: An element whose exponent field is 0 counts as zero whatever its fraction bits hold. Its lane adds nothing to the sum.
- R4: An exact total of zero, including cancellation between lanes of opposite sign, yields +0 (0x0000).
- R5: Rounding happens once, on the exact sum, to nearest with ties to even. A carry out of the fraction during rounding raises the exponent by one.
- R6: A rounded exponent above 63 saturates to the largest finite magnitude with the sum's sign: 0x7FFF or 0xFFFF.
- R7: A rounded exponent below 1 flushes to a zero that keeps the sum's sign (0x0000 or 0x8000). A result never has an exponent field of 0 with a nonzero fraction. The smallest normal value, 0x0200, is kept as it is.
- R8: With the output register enabled (the default), the result changes one clock after the operands and holds its old value until that edge. The reset clears the result to 0x0000. With the register disabled, the result follows the operands in the same cycle.
- R9: The result's sign bit is the sign of the exact sum. It is 0 when every nonzero product is positive, and 1 when every nonzero product is negative.
- R10: For arbitrary operand vectors, the result equals the exact sum of the four products rounded under R5 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_vec | input | 64 | First vector; lane i at bits 16*i+15 : 16*i |
| b_vec | input | 64 | Second vector, same lane placement |
| result | output | 16 | Rounded dot product in the 16-bit layout |

## Verification
The registered instance's result is due exactly one clock after the operands change. The combinational instance's result is due in the same cycle. The bench drives new operands on a falling edge. It checks the combinational instance one time step later, and at that same moment confirms that the registered instance still shows the previous expected value. It then checks the registered instance on the next falling edge, after exactly one rising edge. The bound checker realigns its operand copies by the register latency, so its properties compare each result with the operands that produced it.

// File: rtl/fp16c_pkg.sv
package fp16c_pkg;

  // Outcome of the final normalize/round stage
  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_UNDER  = 2'd2,
    CLS_OVER   = 2'd3
  } res_class_e;

  localparam int DEF_EXP_W = 6;
  localparam int DEF_MAN_W = 9;
  localparam int DEF_BIAS  = 31;
  localparam int DEF_LANES = 4;

endpackage

// File: rtl/fp16c_lane_prod.sv
module fp16c_lane_prod #(
  parameter int EXP_W = 6,
  parameter int MAN_W = 9,
  parameter int MAG_W = 146
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output logic signed [MAG_W:0] term
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ESUM_W = EXP_W + 1;

  logic [EXP_W-1:0]  exp_a, exp_b;
  logic              zero_lane, neg;
  logic [SIG_W-1:0]  sig_a, sig_b;
  logic [PROD_W-1:0] prod;
  logic [ESUM_W-1:0] esum, shamt;
  logic [MAG_W-1:0]  placed;

  assign exp_a     = op_a[W-2:MAN_W];
  assign exp_b     = op_b[W-2:MAN_W];
  assign zero_lane = (exp_a == '0) || (exp_b == '0);
  assign neg       = op_a[W-1] ^ op_b[W-1];
  assign sig_a     = {1'b1, op_a[MAN_W-1:0]};
  assign sig_b     = {1'b1, op_b[MAN_W-1:0]};
  assign prod      = PROD_W'(sig_a) * PROD_W'(sig_b);
  assign esum      = ESUM_W'(exp_a) + ESUM_W'(exp_b);
  // smallest nonzero exponent sum is 2, which maps to bit 0 of the accumulator
  assign shamt     = zero_lane ? '0 : (esum - ESUM_W'(2));
  assign placed    = MAG_W'(prod) << shamt;

  always_comb begin
    if (zero_lane)
      term = '0;
    else if (neg)
      term = -$signed({1'b0, placed});
    else
      term = $signed({1'b0, placed});
  end

endmodule

// File: rtl/fp16c_norm_round.sv
module fp16c_norm_round
  import fp16c_pkg::*;
#(
  parameter int EXP_W = 6,
  parameter int MAN_W = 9,
  parameter int BIAS  = 31,
  parameter int MAG_W = 146
) (
  input  logic signed [MAG_W:0]  acc,
  output logic [EXP_W+MAN_W:0]   res
);
  localparam int LEAD_W    = $clog2(MAG_W);
  localparam int EMAX      = (1 << EXP_W) - 1;
  // exponent field of a result whose leading one sits at accumulator bit 0
  localparam int FIELD_OFS = 2 - BIAS - 2 * MAN_W;

  logic              sgn;
  logic [MAG_W-1:0]  mag, norm;
  logic [LEAD_W-1:0] lead, lz;
  logic [MAN_W-1:0]  keep;
  logic              grd, stk, up, carry;
  logic [MAN_W:0]    rnd;
  int                e_pre, e_fin;
  res_class_e        cls;

  assign sgn = acc[MAG_W];
  assign mag = sgn ? MAG_W'(-acc) : MAG_W'(acc);

  always_comb begin
    lead = '0;
    for (int i = 0; i < MAG_W; i++)
      if (mag[i]) lead = LEAD_W'(i);
  end

  assign lz    = LEAD_W'(MAG_W - 1) - lead;
  assign norm  = mag << lz;
  assign keep  = norm[MAG_W-2 -: MAN_W];
  assign grd   = norm[MAG_W-2-MAN_W];
  assign stk   = |norm[MAG_W-3-MAN_W:0];
  assign up    = grd & (stk | keep[0]);
  assign rnd   = {1'b0, keep} + {{MAN_W{1'b0}}, up};
  assign carry = rnd[MAN_W];

  always_comb begin
    e_pre = int'(lead) + FIELD_OFS;
    e_fin = e_pre + (carry ? 1 : 0);
    if (!norm[MAG_W-1])     cls = CLS_ZERO;
    else if (e_fin > EMAX)  cls = CLS_OVER;
    else if (e_fin < 1)     cls = CLS_UNDER;
    else                    cls = CLS_NORMAL;
  end

  always_comb begin
    unique case (cls)
      CLS_ZERO:  res = '0;
      CLS_OVER:  res = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
      CLS_UNDER: res = {sgn, {(EXP_W+MAN_W){1'b0}}};
      default:   res = {sgn, e_fin[EXP_W-1:0], rnd[MAN_W-1:0]};
    endcase
  end

endmodule

// File: rtl/fp16c_dot4.sv
module fp16c_dot4 #(
  parameter int EXP_W   = 6,
  parameter int MAN_W   = 9,
  parameter int BIAS    = 31,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]       a_vec,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]       b_vec,
  output logic [EXP_W+MAN_W:0]                   result
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int PROD_W = 2 * (MAN_W + 1);
  localparam int SPAN   = 2 * ((1 << EXP_W) - 1) - 2;
  localparam int MAG_W  = PROD_W + SPAN + $clog2(LANES);

  logic signed [MAG_W:0] term [LANES];
  logic signed [MAG_W:0] acc;
  logic [W-1:0]          res_c;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      fp16c_lane_prod #(
        .EXP_W(EXP_W), .MAN_W(MAN_W), .MAG_W(MAG_W)
      ) lane_i (
        .op_a (a_vec[l*W +: W]),
        .op_b (b_vec[l*W +: W]),
        .term (term[l])
      );
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++)
      acc = acc + term[l];
  end

  fp16c_norm_round #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS), .MAG_W(MAG_W)
  ) nr_i (
    .acc (acc),
    .res (res_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] result_q;
      always_ff @(posedge clk) begin
        if (rst) result_q <= '0;
        else     result_q <= res_c;
      end
      assign result = result_q;
    end else begin : g_comb
      assign result = res_c;
    end
  endgenerate

endmodule

// File: rtl/fp16c_dot4_chk.sv
module fp16c_dot4_chk #(
  parameter int EXP_W   = 6,
  parameter int MAN_W   = 9,
  parameter int BIAS    = 31,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                             clk,
  input logic                             rst,
  input logic [LANES*(1+EXP_W+MAN_W)-1:0] a_vec,
  input logic [LANES*(1+EXP_W+MAN_W)-1:0] b_vec,
  input logic [EXP_W+MAN_W:0]             result
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int VW = LANES * W;
  localparam logic [W-1:0] ONE = W'(BIAS) << MAN_W;

  logic [VW-1:0] a_q, b_q, a_al, b_al;
  logic [1:0]    cnt;
  logic          aligned, primed;
  logic          a_all_zero, any_nz, any_pos, any_neg, id_case;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
    a_q <= a_vec;
    b_q <= b_vec;
  end

  assign a_al    = REG_OUT ? a_q : a_vec;
  assign b_al    = REG_OUT ? b_q : b_vec;
  assign aligned = REG_OUT ? (cnt >= 2'd1) : 1'b1;
  assign primed  = REG_OUT ? (cnt >= 2'd2) : (cnt >= 2'd1);

  always_comb begin
    a_all_zero = 1'b1;
    any_nz     = 1'b0;
    any_pos    = 1'b0;
    any_neg    = 1'b0;
    id_case    = (b_al[W-1:0] == ONE) && (a_al[W-2:MAN_W] != '0);
    for (int l = 0; l < LANES; l++) begin
      if (a_al[l*W+MAN_W +: EXP_W] != '0) a_all_zero = 1'b0;
      if (a_al[l*W+MAN_W +: EXP_W] != '0 && b_al[l*W+MAN_W +: EXP_W] != '0) begin
        any_nz = 1'b1;
        if (a_al[l*W+W-1] ^ b_al[l*W+W-1]) any_neg = 1'b1;
        else                               any_pos = 1'b1;
      end
      if (l != 0 && b_al[l*W+MAN_W +: EXP_W] != '0) id_case = 1'b0;
    end
  end

  // R3: zero-exponent A lanes contribute nothing
  a_r3_zero_a: assert property (@(posedge clk) disable iff (rst)
    aligned && a_all_zero |-> result == '0);

  // R7: no denormal-looking output code
  a_r7_no_denorm: assert property (@(posedge clk) disable iff (rst)
    result[W-2:MAN_W] == '0 |-> result[MAN_W-1:0] == '0);

  // R9: sign follows uniform product signs
  a_r9_sign_pos: assert property (@(posedge clk) disable iff (rst)
    aligned && any_nz && !any_neg |-> !result[W-1]);

  a_r9_sign_neg: assert property (@(posedge clk) disable iff (rst)
    aligned && any_nz && !any_pos |-> result[W-1]);

  // R1: lane 0 times 1.0 with all other B lanes zero is exact
  a_r1_identity: assert property (@(posedge clk) disable iff (rst)
    aligned && id_case |-> result == a_al[W-1:0]);

  // R8: result depends only on the aligned operands
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    primed && $stable(a_al) && $stable(b_al) |-> $stable(result));

  // R8: register comes out of reset cleared
  a_r8_reset: assert property (@(posedge clk) disable iff (rst)
    REG_OUT && $past(rst) |-> result == '0);

endmodule

bind fp16c_dot4 fp16c_dot4_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS), .LANES(LANES), .REG_OUT(REG_OUT)
) chk_i (
  .clk(clk), .rst(rst), .a_vec(a_vec), .b_vec(b_vec), .result(result)
);

// File: tb/fp16c_dot4_tb_top.sv
module fp16c_dot4_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a_in = '0, b_in = '0;
  logic [15:0] res_r, res_c;
  int          n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  fp16c_dot4 #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .a_vec(a_in), .b_vec(b_in), .result(res_r));
  fp16c_dot4 #(.REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst(rst), .a_vec(a_in), .b_vec(b_in), .result(res_c));

  function automatic logic [63:0] pk(input logic [15:0] x0, x1, x2, x3);
    return {x3, x2, x1, x0};
  endfunction

  // Exact sum of products, then one round-to-nearest-even into the format
  function automatic logic [15:0] ref_dot(input logic [63:0] a, input logic [63:0] b);
    logic signed [159:0] s;
    logic [159:0] m, t, lowmask;
    int emin, es, msb, ef;
    logic [10:0] mant;
    logic grd, stk, sgn;
    emin = 1000;
    for (int i = 0; i < 4; i++) begin
      es = int'(a[16*i+9 +: 6]) + int'(b[16*i+9 +: 6]);
      if (a[16*i+9 +: 6] != 0 && b[16*i+9 +: 6] != 0 && es < emin) emin = es;
    end
    s = '0;
    for (int i = 0; i < 4; i++) begin
      if (a[16*i+9 +: 6] != 0 && b[16*i+9 +: 6] != 0) begin
        es = int'(a[16*i+9 +: 6]) + int'(b[16*i+9 +: 6]);
        t = 160'({1'b1, a[16*i +: 9]}) * 160'({1'b1, b[16*i +: 9]});
        t = t << (es - emin);
        if (a[16*i+15] ^ b[16*i+15]) s = s - $signed(t);
        else                         s = s + $signed(t);
      end
    end
    if (s == 0) return 16'h0000;
    sgn = s[159];
    m = sgn ? 160'(-s) : 160'(s);
    msb = 0;
    for (int k = 0; k < 160; k++) if (m[k]) msb = k;
    ef = msb + emin - 49;
    if (msb >= 10) begin
      mant = 11'((m >> (msb - 9)) & 160'h3FF);
      grd = m[msb-10];
      lowmask = (160'd1 << (msb - 10)) - 160'd1;
      stk = (m & lowmask) != 0;
    end else begin
      mant = 11'(m << (9 - msb));
      grd = 1'b0;
      stk = 1'b0;
    end
    if (grd && (stk || mant[0])) mant = mant + 11'd1;
    if (mant == 11'd1024) begin
      mant = 11'd512;
      ef = ef + 1;
    end
    if (ef > 63) return {sgn, 15'h7FFF};
    if (ef < 1)  return {sgn, 15'h0000};
    return {sgn, 6'(ef), mant[8:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h (a=%h b=%h)", req, act, exp, a_in, b_in);
    end
  endtask

  logic [15:0] prev_exp;

  // drive on falling edge, comb result checked at once, registered one edge later
  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] exp);
    @(negedge clk);
    a_in = a;
    b_in = b;
    #1;
    chk({req, " comb same cycle (R8)"}, res_c, exp);
    chk("R8 register holds until edge", res_r, prev_exp);
    @(negedge clk);
    chk({req, " registered"}, res_r, exp);
    prev_exp = exp;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [15:0] rnd_op(input int mode);
    logic [15:0] v;
    v = 16'($urandom);
    if (mode == 1) v[14:9] = 6'(26 + ($urandom % 11));
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] wv, ra, rb;
    void'($urandom(32'd20260129));
    wv = pk(16'h3E00, 16'h4000, 16'h4100, 16'h4200);
    a_in = wv;
    b_in = wv;
    repeat (3) @(negedge clk);
    chk("R8 reset clears result", res_r, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 dot of 1..4 after reset", res_r, 16'h47C0);
    prev_exp = 16'h47C0;

    apply("R2 dot of 1..4", wv, wv, 16'h47C0);
    apply("R1 3.0*2.0", pk(16'h4100, 0, 0, 0), pk(16'h4000, 0, 0, 0), 16'h4300);
    apply("R1 identity", pk(16'h4555, 0, 0, 0), pk(16'h3E00, 16'h0100, 0, 0), 16'h4555);
    apply("R3 zero-exponent lanes", pk(16'h01FF, 16'h0155, 0, 16'h8123), wv, 16'h0000);
    apply("R3 mixed zero lane", pk(16'h3E00, 16'h0155, 0, 0), pk(16'h4000, 16'h4200, 0, 0), 16'h4000);
    apply("R4 cancellation", pk(16'h3E00, 16'h3E00, 0, 0), pk(16'h4000, 16'hC000, 0, 0), 16'h0000);
    apply("R4 cancellation neg first", pk(16'hBE00, 16'h3E00, 0, 0), pk(16'h4000, 16'h4000, 0, 0), 16'h0000);
    apply("R5 tie to even down", pk(16'h3E00, 16'h2A00, 0, 0), pk(16'h3E00, 16'h3E00, 0, 0), 16'h3E00);
    apply("R5 tie to even up", pk(16'h3E01, 16'h2A00, 0, 0), pk(16'h3E00, 16'h3E00, 0, 0), 16'h3E02);
    apply("R5 sticky breaks tie", pk(16'h3E00, 16'h2A00, 16'h1600, 0),
          pk(16'h3E00, 16'h3E00, 16'h1600, 0), 16'h3E01);
    apply("R5 carry into exponent", pk(16'h3FFF, 16'h2A00, 0, 0), pk(16'h3E00, 16'h3E00, 0, 0), 16'h4000);
    apply("R6 positive saturation", pk(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF),
          pk(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF), 16'h7FFF);
    apply("R6 negative saturation", pk(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF),
          pk(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF), 16'hFFFF);
    apply("R7 underflow positive", pk(16'h0200, 0, 0, 0), pk(16'h0200, 0, 0, 0), 16'h0000);
    apply("R7 underflow negative", pk(16'h8200, 0, 0, 0), pk(16'h0200, 0, 0, 0), 16'h8000);
    apply("R7 smallest normal kept", pk(16'h0200, 0, 0, 0), pk(16'h3E00, 0, 0, 0), 16'h0200);
    apply("R9 all negative", pk(16'hBE00, 16'hC000, 16'hC100, 16'hC200), wv, 16'hC7C0);
    apply("R9 mixed positive", pk(16'h3E00, 16'hC000, 0, 0), pk(16'h4200, 16'h3E00, 0, 0), 16'h4000);
    apply("R9 mixed negative", pk(16'hBE00, 16'h4000, 0, 0), pk(16'h4200, 16'h3E00, 0, 0), 16'hC000);

    for (int n = 0; n < 3000; n++) begin
      int mode;
      mode = n % 3;
      for (int l = 0; l < 4; l++) begin
        ra[16*l +: 16] = rnd_op(mode == 0 ? 0 : 1);
        rb[16*l +: 16] = rnd_op(mode == 0 ? 0 : 1);
      end
      if (mode == 2) begin
        rb[31:16] = rb[15:0];
        ra[31:16] = {~ra[15], ra[14:1], 1'($urandom)};
      end
      apply("R10 random", ra, rb, ref_dot(ra, rb));
    end

    summary();
    $finish;
  end

endmodule